// File: doc/BRIEF.md
# Clock Alarm and Watchdog Interrupt Controller

This block sits beside a BCD timekeeping core and turns two kinds of events into one interrupt pin. The first is a time-of-day alarm. It compares the current minutes, hours and day of week against three alarm registers. Each alarm register has its own mask bit, so the alarm can fire every minute, every hour, every day or once a week. The second is a watchdog. It is a four-digit BCD down-counter, clocked by a 100 Hz tick, which raises its flag on reaching zero unless software keeps touching the watchdog registers.

A command register selects which source drives the pin, the active level of the pin, and level or pulse signalling. It also holds one mask per source and the two read-only flags. Software reaches every register through a single-cycle host port whose read data is combinational. The alarm flag clears as a side effect of any access to the alarm registers. The watchdog flag clears, and the countdown reloads, on any access to the watchdog registers.

Top module: `alarm_wdog_intc`

## Requirements
- R1: The minute alarm (address 3), hour alarm (address 5) and day alarm (address 7) read back as written, except that bits 6..3 of the day alarm always read 0. Bit 7 of each of these registers is its mask bit.
- R2: The alarm is evaluated only in a cycle where `sec_wrap` is high. A field takes part in the compare only when its mask bit is 0: minutes on bits 6..0, hours on bits 6..0, day on bits 2..0. The supported mask settings are none, day only, day and hour, and all three; all three fires on every `sec_wrap`.
- R3: Command bit 2 masks the time-of-day source and bit 3 masks the watchdog source. Each flag still sets while its mask is 1, but the masked source never drives the pin.
- R4: A read or write of address 3, 5 or 7 clears the time-of-day flag, and with it the pin, at the clock edge of that access.
- R5: The command register is at address 11 with this layout: bit 7 transfer enable (stored only), bit 6 route, bit 5 polarity, bit 4 pulse mode, bit 3 watchdog mask, bit 2 time-of-day mask, bit 1 watchdog flag, bit 0 time-of-day flag. Writes to bits 1..0 have no effect.
- R6: Route = 1 connects the unmasked watchdog flag to the pin; route = 0 connects the unmasked time-of-day flag.
- R7: Polarity = 1 drives the pin high when active and low when idle; polarity = 0 inverts both levels.
- R8: Address 13 holds the seconds digits and address 12 the hundredths digits of a BCD period. After the last access to either register, the watchdog flag sets at the clock edge of the Nth `tick_100hz`, where N is that period read as a decimal number.
- R9: A read or write of address 12 or 13 returns or stores the value, reloads the countdown from the resulting period, and clears the watchdog flag.
- R10: A period of 0000 never raises the flag. After expiry the countdown stays stopped, and in level mode the flag stays set until the next watchdog register access.
- R11: In pulse mode a flag, and the pin it drives, stay active for exactly CLK_KHZ*PULSE_MS clock cycles and then release. In level mode they stay active until the access that clears them.
- R12: After reset every register reads 0, both flags are clear, and the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the current address (combinational) |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours including the 12/24 and AM/PM bits |
| cur_day | input | 3 | Current day of week 1..7 |
| sec_wrap | input | 1 | One-cycle strobe when seconds roll from 59 to 00 |
| tick_100hz | input | 1 | One-cycle strobe every 10 ms |
| irq_pin | output | 1 | Interrupt output |

## Verification
Every flag, and the pin that follows it, changes at the clock edge that samples its cause: the `sec_wrap` strobe, the Nth tick, or the clearing access. The bench therefore drives each stimulus for one cycle starting at a falling edge and samples at the next falling edge. Read data is combinational and shows the state before the access edge. The bench reads it 1 ns after driving the address and before the edge that commits the access, so a read of the command register shows flags already set by earlier edges. The pulse width is measured by counting the falling edges at which the pin is active, and that count must equal the parameterised window.

// File: rtl/alm_pkg.sv
package alm_pkg;
   localparam int REG_W     = 8;
   localparam int ADR_W     = 4;
   localparam int WD_DIGITS = 4;
   localparam int WD_W      = 4 * WD_DIGITS;

   localparam logic [ADR_W-1:0] A_ALM_MIN = 4'h3;
   localparam logic [ADR_W-1:0] A_ALM_HR  = 4'h5;
   localparam logic [ADR_W-1:0] A_ALM_DAY = 4'h7;
   localparam logic [ADR_W-1:0] A_CMD     = 4'hB;
   localparam logic [ADR_W-1:0] A_WD_LO   = 4'hC;
   localparam logic [ADR_W-1:0] A_WD_HI   = 4'hD;

   localparam int SRC_TOD = 0;
   localparam int SRC_WD  = 1;
   localparam int N_SRC   = 2;

   typedef struct packed {
      logic xfer_en;
      logic route_wd;
      logic pol_high;
      logic pulse;
      logic wd_mask;
      logic tod_mask;
   } cmd_t;
endpackage

// File: rtl/bcd_dec.sv
module bcd_dec #(
   parameter int DIGITS = 4
) (
   input  logic [4*DIGITS-1:0] val_i,
   output logic [4*DIGITS-1:0] val_o
);
   logic [DIGITS:0] borrow;
   assign borrow[0] = 1'b1;

   for (genvar d = 0; d < DIGITS; d++) begin : g_dig
      logic [3:0] dig;
      assign dig = val_i[4*d +: 4];
      always_comb begin
         if (!borrow[d]) begin
            val_o[4*d +: 4] = dig;
            borrow[d+1]     = 1'b0;
         end else if (dig == 4'd0) begin
            val_o[4*d +: 4] = 4'd9;
            borrow[d+1]     = 1'b1;
         end else begin
            val_o[4*d +: 4] = dig - 4'd1;
            borrow[d+1]     = 1'b0;
         end
      end
   end
endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
   parameter int DIGITS = 4,
   localparam int W = 4 * DIGITS
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload_i,
   input  logic [W-1:0] load_val_i,
   input  logic         tick_i,
   output logic         expire_o
);
   logic [W-1:0] cnt, cnt_dec;
   logic         run;
   logic         dec_zero;

   bcd_dec #(.DIGITS(DIGITS)) u_dec (.val_i(cnt), .val_o(cnt_dec));

   assign dec_zero = (cnt_dec == '0);
   assign expire_o = tick_i & run & ~reload_i & dec_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (reload_i) begin
         cnt <= load_val_i;
         run <= |load_val_i;
      end else if (tick_i && run) begin
         cnt <= cnt_dec;
         if (dec_zero) run <= 1'b0;
      end
   end
endmodule

// File: rtl/flag_ctl.sv
module flag_ctl #(
   parameter int PULSE_CYC = 375000,
   localparam int CW = $clog2(PULSE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic pulse_i,
   output logic flag_o
);
   logic [CW-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         left   <= '0;
      end else if (clr_i) begin
         flag_o <= 1'b0;
         left   <= '0;
      end else if (set_i) begin
         flag_o <= 1'b1;
         left   <= CW'(PULSE_CYC - 1);
      end else if (flag_o && pulse_i) begin
         if (left == '0) flag_o <= 1'b0;
         else            left   <= left - 1'b1;
      end
   end
endmodule

// File: rtl/alarm_wdog_intc.sv
module alarm_wdog_intc
   import alm_pkg::*;
#(
   parameter int CLK_KHZ  = 125000,
   parameter int PULSE_MS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic             acc_wr,
   input  logic [ADR_W-1:0] acc_addr,
   input  logic [REG_W-1:0] acc_wdata,
   output logic [REG_W-1:0] acc_rdata,
   input  logic [6:0]       cur_min,
   input  logic [6:0]       cur_hour,
   input  logic [2:0]       cur_day,
   input  logic             sec_wrap,
   input  logic             tick_100hz,
   output logic             irq_pin
);
   localparam int PULSE_CYC = CLK_KHZ * PULSE_MS;

   initial begin
      assert (CLK_KHZ >= 1)  else $error("CLK_KHZ must be positive");
      assert (PULSE_MS >= 1) else $error("PULSE_MS must be positive");
      assert (PULSE_CYC < (1 << 30)) else $error("pulse window too long");
   end

   logic [REG_W-1:0] alm_min, alm_hr, wd_lo, wd_hi;
   logic             alm_day_m;
   logic [2:0]       alm_day;
   cmd_t             cmd;

   logic hit_tod, hit_wd, wr_en;
   assign wr_en   = acc_en & acc_wr;
   assign hit_tod = acc_en & ((acc_addr == A_ALM_MIN) | (acc_addr == A_ALM_HR) |
                              (acc_addr == A_ALM_DAY));
   assign hit_wd  = acc_en & ((acc_addr == A_WD_LO) | (acc_addr == A_WD_HI));

   logic [REG_W-1:0] wd_lo_nx, wd_hi_nx;
   assign wd_lo_nx = (wr_en && acc_addr == A_WD_LO) ? acc_wdata : wd_lo;
   assign wd_hi_nx = (wr_en && acc_addr == A_WD_HI) ? acc_wdata : wd_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alm_min   <= '0;
         alm_hr    <= '0;
         alm_day_m <= 1'b0;
         alm_day   <= '0;
         cmd       <= '0;
         wd_lo     <= '0;
         wd_hi     <= '0;
      end else begin
         wd_lo <= wd_lo_nx;
         wd_hi <= wd_hi_nx;
         if (wr_en) begin
            unique case (acc_addr)
               A_ALM_MIN: alm_min <= acc_wdata;
               A_ALM_HR:  alm_hr  <= acc_wdata;
               A_ALM_DAY: begin
                  alm_day_m <= acc_wdata[7];
                  alm_day   <= acc_wdata[2:0];
               end
               A_CMD:     cmd <= cmd_t'(acc_wdata[7:2]);
               default: ;
            endcase
         end
      end
   end

   // time-of-day compare, evaluated on the seconds rollover only
   logic min_ok, hr_ok, day_ok, tod_ev;
   assign min_ok = alm_min[7] | (alm_min[6:0] == cur_min);
   assign hr_ok  = alm_hr[7]  | (alm_hr[6:0]  == cur_hour);
   assign day_ok = alm_day_m  | (alm_day      == cur_day);
   assign tod_ev = sec_wrap & min_ok & hr_ok & day_ok;

   logic wd_ev;
   wd_timer #(.DIGITS(WD_DIGITS)) u_wd (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_i   (hit_wd),
      .load_val_i ({wd_hi_nx, wd_lo_nx}),
      .tick_i     (tick_100hz),
      .expire_o   (wd_ev)
   );

   logic [N_SRC-1:0] src_set, src_clr, src_flag, src_mask;
   assign src_set[SRC_TOD]  = tod_ev;
   assign src_set[SRC_WD]   = wd_ev;
   assign src_clr[SRC_TOD]  = hit_tod;
   assign src_clr[SRC_WD]   = hit_wd;
   assign src_mask[SRC_TOD] = cmd.tod_mask;
   assign src_mask[SRC_WD]  = cmd.wd_mask;

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      flag_ctl #(.PULSE_CYC(PULSE_CYC)) u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (src_set[s]),
         .clr_i   (src_clr[s]),
         .pulse_i (cmd.pulse),
         .flag_o  (src_flag[s])
      );
   end

   logic tod_flag, wd_flag;
   assign tod_flag = src_flag[SRC_TOD];
   assign wd_flag  = src_flag[SRC_WD];

   logic [N_SRC-1:0] src_int;
   logic             pin_act;
   assign src_int = src_flag & ~src_mask;
   assign pin_act = cmd.route_wd ? src_int[SRC_WD] : src_int[SRC_TOD];
   assign irq_pin = cmd.pol_high ? pin_act : ~pin_act;

   always_comb begin
      unique case (acc_addr)
         A_ALM_MIN: acc_rdata = alm_min;
         A_ALM_HR:  acc_rdata = alm_hr;
         A_ALM_DAY: acc_rdata = {alm_day_m, 4'b0000, alm_day};
         A_CMD:     acc_rdata = {cmd, wd_flag, tod_flag};
         A_WD_LO:   acc_rdata = wd_lo;
         A_WD_HI:   acc_rdata = wd_hi;
         default:   acc_rdata = '0;
      endcase
   end
endmodule

// File: rtl/alarm_wdog_chk.sv
module alarm_wdog_chk
   import alm_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             acc_en,
   input logic [ADR_W-1:0] acc_addr,
   input logic             sec_wrap,
   input logic             pulse_mode,
   input logic             route_wd,
   input logic             wd_mask,
   input logic             tod_mask,
   input logic             pol_high,
   input logic             tod_flag,
   input logic             wd_flag,
   input logic             irq_pin
);
   logic tod_hit, wd_hit;
   assign tod_hit = acc_en & ((acc_addr == A_ALM_MIN) | (acc_addr == A_ALM_HR) |
                              (acc_addr == A_ALM_DAY));
   assign wd_hit  = acc_en & ((acc_addr == A_WD_LO) | (acc_addr == A_WD_HI));

   AST_TOD_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tod_flag) |-> $past(sec_wrap)); // R2
   AST_MASK_KEEPS_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (route_wd ? wd_mask : tod_mask) |-> (irq_pin == !pol_high)); // R3
   AST_TOD_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      tod_hit |=> !tod_flag); // R4
   AST_WD_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wd_hit |=> !wd_flag); // R9
   AST_WD_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_flag && !pulse_mode && !wd_hit) |=> wd_flag); // R10
endmodule

bind alarm_wdog_intc alarm_wdog_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_en     (acc_en),
   .acc_addr   (acc_addr),
   .sec_wrap   (sec_wrap),
   .pulse_mode (cmd.pulse),
   .route_wd   (cmd.route_wd),
   .wd_mask    (cmd.wd_mask),
   .tod_mask   (cmd.tod_mask),
   .pol_high   (cmd.pol_high),
   .tod_flag   (tod_flag),
   .wd_flag    (wd_flag),
   .irq_pin    (irq_pin)
);

// File: tb/tb_alarm_wdog_intc.sv
`timescale 1ns/1ps
module tb_alarm_wdog_intc;
   localparam int CLK_KHZ  = 4;
   localparam int PULSE_MS = 3;
   localparam int PULSE    = CLK_KHZ * PULSE_MS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_en = 1'b0, acc_wr = 1'b0;
   logic [3:0] acc_addr = '0;
   logic [7:0] acc_wdata = '0, acc_rdata;
   logic [6:0] cur_min = '0, cur_hour = '0;
   logic [2:0] cur_day = '0;
   logic       sec_wrap = 1'b0, tick_100hz = 1'b0;
   logic       irq_pin;

   int checks = 0, errors = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   alarm_wdog_intc #(.CLK_KHZ(CLK_KHZ), .PULSE_MS(PULSE_MS)) dut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
      .sec_wrap(sec_wrap), .tick_100hz(tick_100hz), .irq_pin(irq_pin));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic [3:0] a, input logic wr, input logic [7:0] d,
                      output logic [7:0] q);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d;
      #1 q = acc_rdata;
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      logic [7:0] q;
      acc(a, 1'b1, d, q);
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] q);
      acc(a, 1'b0, 8'h00, q);
   endtask

   task automatic wrap();
      @(negedge clk); sec_wrap = 1'b1;
      @(negedge clk); sec_wrap = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk); tick_100hz = 1'b1;
      @(negedge clk); tick_100hz = 1'b0;
   endtask

   function automatic int bcd2i(input logic [15:0] b);
      return b[15:12]*1000 + b[11:8]*100 + b[7:4]*10 + b[3:0];
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog timeout actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] q;
      logic [15:0] periods [5];
      periods = '{16'h0001, 16'h0003, 16'h0010, 16'h0099, 16'h0100};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 pin idle", irq_pin, 1);
      foreach (periods[i]) begin end
      for (int a = 0; a < 16; a++) begin
         rd(a[3:0], q);
         chk($sformatf("R12 reg %0d", a), q, 0);
      end

      // R5 flags read-only
      wr(4'hB, 8'hFF);
      rd(4'hB, q);
      chk("R5 cmd readback with flag bits dropped", q, 8'hFC);
      wr(4'hB, 8'h03);
      rd(4'hB, q);
      chk("R5 write to flag bits ignored", q, 8'h00);

      // R1 alarm register readback
      wr(4'h3, 8'hC5); rd(4'h3, q); chk("R1 minute alarm", q, 8'hC5);
      wr(4'h5, 8'hB2); rd(4'h5, q); chk("R1 hour alarm", q, 8'hB2);
      wr(4'h7, 8'hFD); rd(4'h7, q); chk("R1 day alarm bits 6..3 zero", q, 8'h85);

      // R2 mask sweep, R6/R7 pin follows (route tod, active high)
      wr(4'hB, 8'h20);
      for (int m = 0; m < 4; m++) begin
         logic mk_min, mk_hr, mk_day;
         mk_day = (m >= 1); mk_hr = (m >= 2); mk_min = (m >= 3);
         for (int p = 0; p < 8; p++) begin
            int expf;
            wr(4'h3, {mk_min, 7'h45});
            wr(4'h5, {mk_hr,  7'h13});
            wr(4'h7, {mk_day, 7'h05});
            cur_min  = p[0] ? 7'h45 : 7'h46;
            cur_hour = p[1] ? 7'h13 : 7'h14;
            cur_day  = p[2] ? 3'd5  : 3'd6;
            expf = (mk_min | p[0]) & (mk_hr | p[1]) & (mk_day | p[2]);
            wrap();
            chk($sformatf("R2 pin mask=%0d pat=%0d", m, p), irq_pin, expf);
            rd(4'hB, q);
            chk($sformatf("R2 flag mask=%0d pat=%0d", m, p), q[0], expf);
         end
      end

      // R2 no compare without the rollover strobe
      wr(4'h3, 8'h45); wr(4'h5, 8'h13); wr(4'h7, 8'h05);
      cur_min = 7'h45; cur_hour = 7'h13; cur_day = 3'd5;
      repeat (4) @(negedge clk);
      rd(4'hB, q);
      chk("R2 match without sec_wrap ignored", q[0], 0);

      // R3 time-of-day mask: flag sets, pin idle
      wr(4'hB, 8'h24);
      wrap();
      chk("R3 masked tod pin idle", irq_pin, 0);
      rd(4'hB, q);
      chk("R3 masked tod flag still set", q[0], 1);

      // R4 access clears, R11 level holds
      wr(4'hB, 8'h20);
      repeat (PULSE + 5) @(negedge clk);
      chk("R11 level mode pin held", irq_pin, 1);
      rd(4'h5, q);
      chk("R4 read of alarm reg clears pin", irq_pin, 0);
      rd(4'hB, q);
      chk("R4 flag cleared", q[0], 0);

      // R11 pulse window
      wr(4'hB, 8'h30);
      wr(4'h3, 8'h80); wr(4'h5, 8'h80); wr(4'h7, 8'h80);
      wrap();
      begin
         int n = 0;
         for (int c = 0; c < PULSE + 20; c++) begin
            if (irq_pin) n++;
            @(negedge clk);
         end
         chk("R11 pulse width cycles", n, PULSE);
      end
      rd(4'hB, q);
      chk("R11 pulse flag released", q[0], 0);

      // R8/R9/R10 watchdog periods, level mode, route wd
      wr(4'hB, 8'h60);
      foreach (periods[i]) begin
         int first, n;
         first = -1;
         n = bcd2i(periods[i]);
         wr(4'hD, periods[i][15:8]);
         wr(4'hC, periods[i][7:0]);
         for (int t = 1; t <= n + 2; t++) begin
            tick();
            rd(4'hB, q);
            if (q[1] && first < 0) first = t;
         end
         chk($sformatf("R8 expiry tick for %0h", periods[i]), first, n);
         chk($sformatf("R10 flag held after expiry %0h", periods[i]), q[1], 1);
         chk($sformatf("R6 wd routed pin %0h", periods[i]), irq_pin, 1);
         rd(4'hC, q);
         chk($sformatf("R9 lo readback %0h", periods[i]), q, periods[i][7:0]);
         rd(4'hD, q);
         chk($sformatf("R9 hi readback %0h", periods[i]), q, periods[i][15:8]);
         rd(4'hB, q);
         chk($sformatf("R9 access cleared flag %0h", periods[i]), q[1], 0);
      end

      // R9 reload restarts count (period 0003)
      wr(4'hD, 8'h00); wr(4'hC, 8'h03);
      tick(); tick();
      rd(4'hC, q);
      tick(); tick();
      rd(4'hB, q);
      chk("R9 reload restarted countdown", q[1], 0);
      tick();
      rd(4'hB, q);
      chk("R9 expiry three ticks after reload", q[1], 1);

      // R3 watchdog mask, R7 polarity, R6 routing
      wr(4'hB, 8'h68);
      chk("R3 masked wd pin idle", irq_pin, 0);
      rd(4'hB, q);
      chk("R3 masked wd flag set", q[1], 1);
      wr(4'hB, 8'h40);
      chk("R7 active-low pin", irq_pin, 0);
      wr(4'hB, 8'h60);
      rd(4'hC, q);
      wr(4'h3, 8'h80); wr(4'h5, 8'h80); wr(4'h7, 8'h80);
      wrap();
      chk("R6 tod not routed when route=1", irq_pin, 0);
      wr(4'hB, 8'h20);
      chk("R6 tod routed when route=0", irq_pin, 1);
      wr(4'hB, 8'h00);
      chk("R7 active-low tod", irq_pin, 0);

      // R10 zero period disables
      wr(4'hD, 8'h00); wr(4'hC, 8'h00);
      for (int t = 0; t < 120; t++) tick();
      rd(4'hB, q);
      chk("R10 zero period never expires", q[1], 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule